// File: doc/BRIEF.md
# Time-Measurement Requester Dialog Engine

This block runs the requesting side of a two-way time-measurement exchange on the upstream-facing port of a serial link. A trigger opens a dialog. The engine offers a request message on a valid/ready output. On the handshake it stamps the request with the local time (T1). It then waits on a valid/ready input for the answer and stamps that with the local time (T4). The local time comes from a free-running 64-bit counter that sits outside the block and drives `local_time_i`.

An answer is either plain or delayed. A plain answer only closes the dialog. A delayed answer brings two values: the master time at which the partner took the current request, and the partner's turnaround time from the previous dialog. With these the engine pairs the previous dialog's T1 and T4 to work out the one-way link delay, including a programmable asymmetry correction. From that it derives the master time that corresponds to the local time of the current request.

Retransmitted requests and repeated answers move the stored stamps to the latest event. In enhanced mode they also mark dialogs as unusable, and a result is produced only when both dialogs involved are clean.

Back-pressure rules:
- The request stays offered until `req_ready_i` is seen high.
- An answer is taken only in a cycle where `rsp_ready_o` is high, which is the case only while a request is outstanding.
- The result output is a one-cycle pulse and takes no back-pressure.

Top module: `ptm_req_engine`

## Requirements
- R1: After reset, `req_valid_o`, `rsp_ready_o` and `res_valid_o` are low.
- R2: A trigger accepted while no dialog is in flight raises `req_valid_o` in the next cycle. `req_valid_o` stays high until a cycle in which `req_ready_i` is high. At that handshake T1 takes the value of `local_time_i`. In the following cycle `req_valid_o` is low and `rsp_ready_o` is high.
- R3: Only one dialog is in flight at a time. A trigger that arrives while `req_valid_o` or `rsp_ready_o` is high is ignored, so no second request follows the answer.
- R4: An answer handshake (`rsp_valid_i` and `rsp_ready_o` both high) stores T4 from `local_time_i` and lowers `rsp_ready_o` in the next cycle. A plain answer (`rsp_delayed_i` = 0) produces no result.
- R5: Suppose a delayed answer (`rsp_delayed_i` = 1) completes a clean dialog whose predecessor was also clean. Then `res_valid_o` is high for exactly one cycle, the cycle after the handshake.
  - `res_link_o` is the low 32 bits of S/2, where S = (T4p − T1p modulo 2^64, read as signed) − `rsp_prop_i` (unsigned) + `asym_i` (signed), and T1p and T4p belong to the previous dialog.
  - `res_master_o` is `rsp_master_i` minus the sign-extended `res_link_o`.
- R6: The first dialog after reset has no predecessor, so a delayed answer to it produces no result.
- R7: A replay indication while the answer is awaited moves T1 to the `local_time_i` of that cycle. With `enh_mode_i` = 0 the dialog stays clean.
- R8: With `enh_mode_i` = 1, a replay marks both the current dialog and the next one unclean. No result appears until two clean dialogs follow in a row.
- R9: A duplicate-answer indication after a dialog is complete moves its T4 to the `local_time_i` of that cycle. With `enh_mode_i` = 1 that dialog also becomes unclean.
- R10: The halving in S/2 rounds toward zero, so a negative S of −21 yields −10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| local_time_i | input | 64 | Free-running local time count |
| enh_mode_i | input | 1 | 1 selects enhanced invalidation rules |
| asym_i | input | 32 | Signed link asymmetry, half of it enters the delay |
| trig_i | input | 1 | Start a new dialog |
| req_valid_o | output | 1 | Request offered to the link |
| req_ready_i | input | 1 | Link takes the request this cycle |
| replay_i | input | 1 | Request was retransmitted this cycle |
| rsp_valid_i | input | 1 | Answer present |
| rsp_ready_o | output | 1 | Answer accepted this cycle |
| rsp_delayed_i | input | 1 | 1 = delayed answer with time fields |
| rsp_master_i | input | 64 | Master time of the current request |
| rsp_prop_i | input | 32 | Partner turnaround of the previous dialog |
| dup_i | input | 1 | Duplicate answer received this cycle |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_link_o | output | 32 | Signed one-way link delay |
| res_master_o | output | 64 | Master time at local T1 |

## Verification
The delay arithmetic is driven from a table of dialog sequences. The table covers:
- a plain symmetric link;
- a positive and a negative asymmetry;
- a T1 just below the 64-bit wrap paired with a T4 just past it, which separates modular from non-modular subtraction;
- an odd sum, which exposes wrong rounding;
- a negative sum, which separates rounding toward zero from flooring.

Directed sequences then repeat triggers during the send and wait phases, and they issue replays and duplicates in both modes. These show whether each event moves the right stamp, and whether the enhanced mode blocks exactly the dialogs that should be blocked: the replayed one, the one after it, and the dialog whose predecessor was unclean.

// File: rtl/ptm_req_pkg.sv
package ptm_req_pkg;
  typedef enum logic [1:0] {
    DLG_IDLE = 2'd0,
    DLG_SEND = 2'd1,
    DLG_WAIT = 2'd2,
    DLG_DONE = 2'd3
  } dlg_state_e;
endpackage

// File: rtl/ptm_req_fsm.sv
module ptm_req_fsm
  import ptm_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic start_o,
  output logic req_fire_o,
  output logic rsp_fire_o,
  output logic req_valid_o,
  output logic rsp_ready_o,
  output logic in_done_o
);
  dlg_state_e state_q, state_d;

  assign req_valid_o = (state_q == DLG_SEND);
  assign rsp_ready_o = (state_q == DLG_WAIT);
  assign in_done_o   = (state_q == DLG_DONE);
  assign start_o     = trig_i && ((state_q == DLG_IDLE) || (state_q == DLG_DONE));
  assign req_fire_o  = req_valid_o && req_ready_i;
  assign rsp_fire_o  = rsp_ready_o && rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DLG_IDLE, DLG_DONE: if (start_o)    state_d = DLG_SEND;
      DLG_SEND:           if (req_fire_o) state_d = DLG_WAIT;
      DLG_WAIT:           if (rsp_fire_o) state_d = DLG_DONE;
      default:            state_d = DLG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= DLG_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ptm_req_stamps.sv
module ptm_req_stamps #(
  parameter int TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] local_time_i,
  input  logic            enh_mode_i,
  input  logic            start_i,
  input  logic            req_fire_i,
  input  logic            rsp_fire_i,
  input  logic            in_wait_i,
  input  logic            in_done_i,
  input  logic            replay_i,
  input  logic            dup_i,
  output logic [TS_W-1:0] prev_t1_o,
  output logic [TS_W-1:0] prev_t4_o,
  output logic            prev_ok_o,
  output logic            cur_ok_o
);
  logic [TS_W-1:0] cur_t1_q, cur_t4_q;
  logic            poison_q;
  logic            replay_hit, dup_hit;

  assign replay_hit = replay_i && in_wait_i;
  assign dup_hit    = dup_i && in_done_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_t1_q  <= '0;
      cur_t4_q  <= '0;
      prev_t1_o <= '0;
      prev_t4_o <= '0;
      prev_ok_o <= 1'b0;
      cur_ok_o  <= 1'b0;
      poison_q  <= 1'b0;
    end else begin
      if (start_i) begin
        prev_t1_o <= cur_t1_q;
        prev_t4_o <= cur_t4_q;
        prev_ok_o <= cur_ok_o;
        cur_ok_o  <= !poison_q;
        poison_q  <= 1'b0;
      end
      if (req_fire_i) cur_t1_q <= local_time_i;
      if (replay_hit) begin
        cur_t1_q <= local_time_i;
        if (enh_mode_i) begin
          cur_ok_o <= 1'b0;
          poison_q <= 1'b1;
        end
      end
      if (rsp_fire_i) cur_t4_q <= local_time_i;
      if (dup_hit) begin
        cur_t4_q <= local_time_i;
        if (enh_mode_i) cur_ok_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptm_req_calc.sv
module ptm_req_calc #(
  parameter int TS_W = 64,
  parameter int LD_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [TS_W-1:0] prev_t1_i,
  input  logic [TS_W-1:0] prev_t4_i,
  input  logic [LD_W-1:0] prop_i,
  input  logic [LD_W-1:0] asym_i,
  input  logic [TS_W-1:0] master_i,
  output logic            res_valid_o,
  output logic [LD_W-1:0] res_link_o,
  output logic [TS_W-1:0] res_master_o
);
  localparam int SW  = TS_W + 2;
  localparam int EXT = SW - LD_W;

  logic [TS_W-1:0] rtt;
  logic [SW-1:0]   sum, adj;
  logic [LD_W-1:0] link_c;

  assign rtt    = prev_t4_i - prev_t1_i;
  assign sum    = {{2{rtt[TS_W-1]}}, rtt} - {{EXT{1'b0}}, prop_i}
                + {{EXT{asym_i[LD_W-1]}}, asym_i};
  assign adj    = sum + {{(SW-1){1'b0}}, sum[SW-1]};
  assign link_c = adj[LD_W:1];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_link_o   <= '0;
      res_master_o <= '0;
    end else begin
      res_valid_o <= fire_i;
      if (fire_i) begin
        res_link_o   <= link_c;
        res_master_o <= master_i - {{(TS_W-LD_W){link_c[LD_W-1]}}, link_c};
      end
    end
  end
endmodule

// File: rtl/ptm_req_engine.sv
module ptm_req_engine #(
  parameter int TS_W = 64,
  parameter int LD_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] local_time_i,
  input  logic            enh_mode_i,
  input  logic [LD_W-1:0] asym_i,
  input  logic            trig_i,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  input  logic            replay_i,
  input  logic            rsp_valid_i,
  output logic            rsp_ready_o,
  input  logic            rsp_delayed_i,
  input  logic [TS_W-1:0] rsp_master_i,
  input  logic [LD_W-1:0] rsp_prop_i,
  input  logic            dup_i,
  output logic            res_valid_o,
  output logic [LD_W-1:0] res_link_o,
  output logic [TS_W-1:0] res_master_o
);
  logic            start, req_fire, rsp_fire, in_done;
  logic [TS_W-1:0] prev_t1, prev_t4;
  logic            prev_ok, cur_ok, calc_fire;

  ptm_req_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
    .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
    .start_o(start), .req_fire_o(req_fire), .rsp_fire_o(rsp_fire),
    .req_valid_o(req_valid_o), .rsp_ready_o(rsp_ready_o), .in_done_o(in_done)
  );

  ptm_req_stamps #(.TS_W(TS_W)) u_stamps (
    .clk_i(clk_i), .rst_ni(rst_ni), .local_time_i(local_time_i),
    .enh_mode_i(enh_mode_i), .start_i(start), .req_fire_i(req_fire),
    .rsp_fire_i(rsp_fire), .in_wait_i(rsp_ready_o), .in_done_i(in_done),
    .replay_i(replay_i), .dup_i(dup_i),
    .prev_t1_o(prev_t1), .prev_t4_o(prev_t4),
    .prev_ok_o(prev_ok), .cur_ok_o(cur_ok)
  );

  assign calc_fire = rsp_fire && rsp_delayed_i && prev_ok && cur_ok;

  ptm_req_calc #(.TS_W(TS_W), .LD_W(LD_W)) u_calc (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(calc_fire),
    .prev_t1_i(prev_t1), .prev_t4_i(prev_t4), .prop_i(rsp_prop_i),
    .asym_i(asym_i), .master_i(rsp_master_i),
    .res_valid_o(res_valid_o), .res_link_o(res_link_o),
    .res_master_o(res_master_o)
  );
endmodule

// File: rtl/ptm_req_chk.sv
module ptm_req_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_o,
  input logic req_ready_i,
  input logic rsp_valid_i,
  input logic rsp_ready_o,
  input logic rsp_delayed_i,
  input logic res_valid_o
);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o);
  // R2
  req_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> rsp_ready_o && !req_valid_o);
  // R3
  one_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_valid_o, rsp_ready_o}));
  // R4
  rsp_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o |=> !rsp_ready_o);
  // R4
  plain_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o && !rsp_delayed_i |=> !res_valid_o);
  // R5
  res_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(rsp_valid_i && rsp_ready_o && rsp_delayed_i));
  // R5
  res_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

bind ptm_req_engine ptm_req_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
  .rsp_ready_o(rsp_ready_o), .rsp_delayed_i(rsp_delayed_i),
  .res_valid_o(res_valid_o)
);

// File: tb/ptm_req_engine_tb_top.sv
`timescale 1ns/1ps
module ptm_req_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] local_time_i = '0;
  logic        enh_mode_i = 1'b0;
  logic [31:0] asym_i = '0;
  logic        trig_i = 1'b0, req_ready_i = 1'b0, replay_i = 1'b0;
  logic        rsp_valid_i = 1'b0, rsp_delayed_i = 1'b0, dup_i = 1'b0;
  logic [63:0] rsp_master_i = '0;
  logic [31:0] rsp_prop_i = '0;
  logic        req_valid_o, rsp_ready_o, res_valid_o;
  logic [31:0] res_link_o;
  logic [63:0] res_master_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ptm_req_engine dut_i (.*);

  // requirement model
  logic [63:0] m_pt1 = '0, m_pt4 = '0, m_ct1 = '0, m_ct4 = '0;
  bit m_pok = 0, m_cok = 0, m_poison = 0;

  localparam int NV = 6;
  localparam logic [63:0] V_T1 [NV] = '{64'd100, 64'd1000, 64'd2000,
    64'hFFFF_FFFF_FFFF_FFE2, 64'd5000, 64'd6000};
  localparam logic [63:0] V_T4 [NV] = '{64'd160, 64'd1070, 64'd2050,
    64'd10, 64'd5010, 64'd6090};
  localparam logic [63:0] V_M [NV] = '{64'd5000, 64'd9000, 64'd20000,
    64'd30000, 64'd77777, 64'd90000};
  localparam logic [31:0] V_P [NV] = '{32'd20, 32'd20, 32'd30,
    32'd11, 32'd10, 32'd30};
  localparam logic [31:0] V_A [NV] = '{32'd0, 32'd0, 32'd6,
    32'd0, 32'hFFFF_FFF9, 32'hFFFF_FFFF};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic trigger();
    @(negedge clk_i) trig_i = 1'b1;
    @(negedge clk_i) trig_i = 1'b0;
    m_pt1 = m_ct1; m_pt4 = m_ct4; m_pok = m_cok;
    m_cok = !m_poison; m_poison = 0;
  endtask

  task automatic send(input logic [63:0] t);
    local_time_i = t; req_ready_i = 1'b1;
    @(negedge clk_i) req_ready_i = 1'b0;
    m_ct1 = t;
  endtask

  task automatic replay(input logic [63:0] t);
    local_time_i = t; replay_i = 1'b1;
    @(negedge clk_i) replay_i = 1'b0;
    m_ct1 = t;
    if (enh_mode_i) begin m_cok = 0; m_poison = 1; end
  endtask

  task automatic dup(input logic [63:0] t);
    @(negedge clk_i) local_time_i = t; dup_i = 1'b1;
    @(negedge clk_i) dup_i = 1'b0;
    m_ct4 = t;
    if (enh_mode_i) m_cok = 0;
  endtask

  task automatic respond(input logic [63:0] t, input bit dly,
                         input logic [63:0] m, input logic [31:0] p,
                         input string req);
    longint s, lk;
    logic [31:0] lk32;
    logic [63:0] mexp;
    bit want;
    want = dly && m_pok && m_cok;
    s = $signed(m_pt4 - m_pt1) - longint'({32'd0, p}) + longint'($signed(asym_i));
    lk = s / 2;
    lk32 = lk[31:0];
    mexp = m - {{32{lk32[31]}}, lk32};
    local_time_i = t; rsp_valid_i = 1'b1; rsp_delayed_i = dly;
    rsp_master_i = m; rsp_prop_i = p;
    @(negedge clk_i) rsp_valid_i = 1'b0;
    m_ct4 = t;
    chk(res_valid_o == want, req, "res_valid", res_valid_o, want);
    if (want) begin
      chk(res_link_o == lk32, req, "link", $signed(res_link_o), $signed(lk32));
      chk(res_master_o == mexp, req, "master", res_master_o, mexp);
    end
    chk(rsp_ready_o == 1'b0, "R4", "rsp_ready after answer", rsp_ready_o, 0);
  endtask

  task automatic dialog(input logic [63:0] t1, input logic [63:0] t4,
                        input bit dly, input logic [63:0] m,
                        input logic [31:0] p, input string req);
    trigger();
    send(t1);
    respond(t4, dly, m, p, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_valid_o == 0, "R1", "req_valid in reset", req_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_valid_o == 0, "R1", "req_valid", req_valid_o, 0);
    chk(rsp_ready_o == 0, "R1", "rsp_ready", rsp_ready_o, 0);
    chk(res_valid_o == 0, "R1", "res_valid", res_valid_o, 0);

    // R2 hold and handoff, with R6 on the first (predecessor-less) dialog
    trigger();
    chk(req_valid_o == 1, "R2", "req_valid after trigger", req_valid_o, 1);
    repeat (2) @(negedge clk_i);
    chk(req_valid_o == 1, "R2", "req_valid held", req_valid_o, 1);
    send(V_T1[0]);
    chk(req_valid_o == 0, "R2", "req_valid after handshake", req_valid_o, 0);
    chk(rsp_ready_o == 1, "R2", "rsp_ready after handshake", rsp_ready_o, 1);
    asym_i = V_A[0];
    respond(V_T4[0], 1'b1, V_M[0], V_P[0], "R6");

    // table walk: R5 and R10 (entry 5 has a negative sum)
    for (int i = 1; i < NV; i++) begin
      asym_i = V_A[i];
      dialog(V_T1[i], V_T4[i], 1'b1, V_M[i], V_P[i], (i == NV-1) ? "R10" : "R5");
    end
    asym_i = '0;

    // R3 triggers during send and wait are ignored
    trigger();
    @(negedge clk_i) trig_i = 1'b1;
    @(negedge clk_i) trig_i = 1'b0;
    send(64'd8000);
    @(negedge clk_i) trig_i = 1'b1;
    @(negedge clk_i) trig_i = 1'b0;
    respond(64'd8040, 1'b0, 64'd0, 32'd0, "R4");
    @(negedge clk_i);
    chk(req_valid_o == 0, "R3", "no second request", req_valid_o, 0);
    chk(rsp_ready_o == 0, "R3", "no second wait", rsp_ready_o, 0);

    // R7 replay, standard mode
    trigger();
    send(64'd10000);
    replay(64'd10004);
    respond(64'd10060, 1'b0, 64'd0, 32'd0, "R7");
    dialog(64'd11000, 64'd11050, 1'b1, 64'd40000, 32'd16, "R7");

    // R9 duplicate, standard mode
    dup(64'd11090);
    dialog(64'd12000, 64'd12030, 1'b1, 64'd50000, 32'd10, "R9");

    // R8 replay, enhanced mode
    enh_mode_i = 1'b1;
    dialog(64'd13000, 64'd13030, 1'b1, 64'd60000, 32'd10, "R8");
    trigger();
    send(64'd14000);
    replay(64'd14002);
    respond(64'd14040, 1'b1, 64'd61000, 32'd10, "R8");
    dialog(64'd15000, 64'd15030, 1'b1, 64'd62000, 32'd10, "R8");
    dialog(64'd16000, 64'd16030, 1'b1, 64'd63000, 32'd10, "R8");
    dialog(64'd17000, 64'd17030, 1'b1, 64'd64000, 32'd10, "R8");

    // R9 duplicate, enhanced mode
    dup(64'd17100);
    dialog(64'd18000, 64'd18030, 1'b1, 64'd65000, 32'd10, "R9");
    dialog(64'd19000, 64'd19030, 1'b1, 64'd66000, 32'd10, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule